// File: doc/BRIEF.md
# Two-Port Trunk Selector with Failover

This block sits beside the forwarding logic of a small switch and lets two physical ports, numbered 0 and 1, act as one logical link when the trunk mode input is high. Each transmit request names a destination port. When that port belongs to the trunk, the block picks the physical member by hashing the frame's source and destination MAC addresses. A given address pair therefore always leaves on the same member, which keeps the frames of one conversation in order. When one member's link is down, all trunk traffic moves to the member that is still up. When neither member is up, the request is reported as not deliverable.

On the receive side, the block compares the port a frame arrived on with the port that the address table has learned for that frame's source address, and raises a relearn flag when they disagree. While trunking is on, ports 0 and 1 count as the same port for this comparison. The address table itself sits outside the block. Both results are registered and appear one clock after their inputs.

Top module: `trunk_selector`

## Requirements
- R1: While reset is high, and on the first clock edge after it is released with no request presented, sel_valid, sel_port and relearn are all 0.
- R2: Every output is registered. A request presented before a rising edge shows on the outputs only after that edge and not before it.
- R3: With trunk_en low, a request (req_valid high) gives sel_valid=1 and sel_port=req_port, whatever the values of link_up, sa and da.
- R4: With trunk_en high, req_port equal to 0 or 1, and link_up=2'b11, sel_port is the XOR of all 48 sa bits and all 48 da bits: a result of 0 selects port 0 and a result of 1 selects port 1. The same address pair always gives the same port.
- R5: With trunk_en high and req_port equal to 0 or 1, link_up=2'b01 (bit 0 is port 0's link) selects port 0, and link_up=2'b10 selects port 1, whatever the hash gives. sel_valid is 1 in both cases.
- R6: With trunk_en high, req_port equal to 0 or 1, and link_up=2'b00, the outputs are sel_valid=0 and sel_port=0.
- R7: With trunk_en high, a request for a port of 2 or above passes through unchanged with sel_valid=1.
- R8: When req_valid is low, the next outputs are sel_valid=0 and sel_port=0.
- R9: With trunk_en high and rx_port equal to 0 or 1, relearn is 0 when learned_port is 0 or 1, and 1 for any other learned_port.
- R10: With trunk_en low, or with rx_port of 2 or above, relearn is 1 exactly when learned_port differs from rx_port.
- R11: When rx_valid is low, the next relearn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trunk_en | input | 1 | High: ports 0 and 1 form one logical link |
| link_up | input | 2 | Link status; bit 0 is port 0, bit 1 is port 1 |
| req_valid | input | 1 | A transmit request is present |
| req_port | input | 3 | Destination port asked for by forwarding |
| sa | input | 48 | Source MAC address of the frame |
| da | input | 48 | Destination MAC address of the frame |
| rx_valid | input | 1 | A source check is requested for a received frame |
| rx_port | input | 3 | Port the frame arrived on |
| learned_port | input | 3 | Port the address table holds for the source address |
| sel_valid | output | 1 | The selected port can be used |
| sel_port | output | 3 | Physical port chosen for the request |
| relearn | output | 1 | The source address must be relearned |

## Verification
Both the port selection and the relearn flag are due at the first rising edge after their inputs are applied. The bench changes inputs on the falling edge and reads the outputs 1 ns after the next rising edge. For the latency requirement it also reads the outputs just before that edge, to show that nothing has moved yet. The hash cases use address pairs whose bit count can be found by hand, and the failover cases choose pairs whose hash points at the port that is down, so the result shows that failover overrides the hash.

// File: rtl/trunk_sel_pkg.sv
package trunk_sel_pkg;

    localparam int MAC_W  = 48;
    localparam int PORT_W = 3;

    typedef logic [PORT_W-1:0] port_id_t;

    typedef struct packed {
        logic     valid;
        port_id_t port;
    } sel_t;

    typedef enum logic [1:0] {
        LINKS_NONE = 2'b00,
        ONLY_P0    = 2'b01,
        ONLY_P1    = 2'b10,
        LINKS_BOTH = 2'b11
    } link_state_e;

    function automatic logic is_member(port_id_t p);
        return (p == port_id_t'(0)) || (p == port_id_t'(1));
    endfunction

endpackage

// File: rtl/trunk_hash.sv
module trunk_hash #(
    parameter int W = trunk_sel_pkg::MAC_W
) (
    input  logic [W-1:0] sa,
    input  logic [W-1:0] da,
    output logic         pick
);
    logic [W-1:0] mixed;
    logic [W:0]   chain;

    assign mixed    = sa ^ da;
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fold
        assign chain[i+1] = chain[i] ^ mixed[i];
    end

    assign pick = chain[W];
endmodule

// File: rtl/trunk_member_pick.sv
module trunk_member_pick
    import trunk_sel_pkg::*;
(
    input  logic        trunk_en,
    input  logic [1:0]  link_up,
    input  logic        req_valid,
    input  port_id_t    req_port,
    input  logic        hash_bit,
    output sel_t        nxt
);
    link_state_e ls;

    assign ls = link_state_e'(link_up);

    always_comb begin
        nxt = '0;
        if (req_valid) begin
            if (trunk_en && is_member(req_port)) begin
                unique case (ls)
                    LINKS_BOTH: nxt = '{valid: 1'b1, port: port_id_t'(hash_bit)};
                    ONLY_P0:    nxt = '{valid: 1'b1, port: port_id_t'(0)};
                    ONLY_P1:    nxt = '{valid: 1'b1, port: port_id_t'(1)};
                    default:    nxt = '0;
                endcase
            end else begin
                nxt = '{valid: 1'b1, port: req_port};
            end
        end
    end
endmodule

// File: rtl/trunk_src_check.sv
module trunk_src_check
    import trunk_sel_pkg::*;
(
    input  logic     trunk_en,
    input  logic     rx_valid,
    input  port_id_t rx_port,
    input  port_id_t learned_port,
    output logic     relearn_nxt
);
    always_comb begin
        relearn_nxt = 1'b0;
        if (rx_valid) begin
            if (trunk_en && is_member(rx_port))
                relearn_nxt = !is_member(learned_port);
            else
                relearn_nxt = (learned_port != rx_port);
        end
    end
endmodule

// File: rtl/trunk_selector.sv
module trunk_selector
    import trunk_sel_pkg::*;
#(
    parameter int ADDR_W = trunk_sel_pkg::MAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trunk_en,
    input  logic [1:0]        link_up,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [ADDR_W-1:0] sa,
    input  logic [ADDR_W-1:0] da,
    input  logic              rx_valid,
    input  logic [PORT_W-1:0] rx_port,
    input  logic [PORT_W-1:0] learned_port,
    output logic              sel_valid,
    output logic [PORT_W-1:0] sel_port,
    output logic              relearn
);
    logic hash_bit;
    sel_t sel_nxt;
    sel_t sel_q;
    logic relearn_nxt;
    logic relearn_q;

    trunk_hash #(.W(ADDR_W)) u_hash (
        .sa   (sa),
        .da   (da),
        .pick (hash_bit)
    );

    trunk_member_pick u_pick (
        .trunk_en  (trunk_en),
        .link_up   (link_up),
        .req_valid (req_valid),
        .req_port  (req_port),
        .hash_bit  (hash_bit),
        .nxt       (sel_nxt)
    );

    trunk_src_check u_chk (
        .trunk_en     (trunk_en),
        .rx_valid     (rx_valid),
        .rx_port      (rx_port),
        .learned_port (learned_port),
        .relearn_nxt  (relearn_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            relearn_q <= 1'b0;
        end else begin
            sel_q     <= sel_nxt;
            relearn_q <= relearn_nxt;
        end
    end

    assign sel_valid = sel_q.valid;
    assign sel_port  = sel_q.port;
    assign relearn   = relearn_q;

    // R3: trunk off means pass-through
    a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
        (!trunk_en && req_valid) |=> (sel_valid && sel_port == $past(req_port)));

    // R5: failover to the member that is still up
    a_r5_failover_p0: assert property (@(posedge clk) disable iff (rst)
        (trunk_en && req_valid && is_member(req_port) && link_up == 2'b01)
        |=> (sel_valid && sel_port == port_id_t'(0)));

    a_r5_failover_p1: assert property (@(posedge clk) disable iff (rst)
        (trunk_en && req_valid && is_member(req_port) && link_up == 2'b10)
        |=> (sel_valid && sel_port == port_id_t'(1)));

    // R6: no member up means no valid selection
    a_r6_both_down: assert property (@(posedge clk) disable iff (rst)
        (trunk_en && req_valid && is_member(req_port) && link_up == 2'b00)
        |=> !sel_valid);

    // R8: no request, no valid output
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !sel_valid);

    // R9: trunk members are interchangeable for learning
    a_r9_member_ok: assert property (@(posedge clk) disable iff (rst)
        (trunk_en && rx_valid && is_member(rx_port) && is_member(learned_port))
        |=> !relearn);

    // R11: no check requested, no relearn
    a_r11_quiet_rx: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !relearn);
endmodule

// File: tb/trunk_selector_tb_top.sv
module trunk_selector_tb_top;

    typedef struct packed {
        logic        te;
        logic [1:0]  lk;
        logic        rv;
        logic [2:0]  rp;
        logic [47:0] sa;
        logic [47:0] da;
        logic        xv;
        logic [2:0]  xp;
        logic [2:0]  lp;
        logic        ev;
        logic [2:0]  ep;
        logic        er;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R3 R10: trunk off, rx 0 learned 1 -> relearn
        '{1'b0, 2'b11, 1'b1, 3'd1, 48'h1, 48'h0, 1'b1, 3'd0, 3'd1, 1'b1, 3'd1, 1'b1},
        // R3: links ignored with trunk off; R10 match -> no relearn
        '{1'b0, 2'b00, 1'b1, 3'd0, 48'h1, 48'h0, 1'b1, 3'd2, 3'd2, 1'b1, 3'd0, 1'b0},
        // R4 odd parity -> port 1; R9 member accepted
        '{1'b1, 2'b11, 1'b1, 3'd0, 48'h1, 48'h0, 1'b1, 3'd0, 3'd1, 1'b1, 3'd1, 1'b0},
        // R4 even parity -> port 0; R9 learned 3 -> relearn
        '{1'b1, 2'b11, 1'b1, 3'd1, 48'h3, 48'h0, 1'b1, 3'd1, 3'd3, 1'b1, 3'd0, 1'b1},
        // R4 four ones -> port 0; R10 non-member match
        '{1'b1, 2'b11, 1'b1, 3'd0, 48'h7, 48'h1, 1'b1, 3'd3, 3'd3, 1'b1, 3'd0, 1'b0},
        // R4 49 ones -> port 1; R10 non-member mismatch
        '{1'b1, 2'b11, 1'b1, 3'd1, 48'hFFFF_FFFF_FFFF, 48'h8000_0000_0000, 1'b1, 3'd4, 3'd2, 1'b1, 3'd1, 1'b1},
        // R5 only port 0 up, hash says 1; R11 rx idle
        '{1'b1, 2'b01, 1'b1, 3'd1, 48'h1, 48'h0, 1'b0, 3'd0, 3'd5, 1'b1, 3'd0, 1'b0},
        // R5 only port 1 up, hash says 0
        '{1'b1, 2'b10, 1'b1, 3'd0, 48'h3, 48'h0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd1, 1'b0},
        // R6 both down
        '{1'b1, 2'b00, 1'b1, 3'd0, 48'h1, 48'h0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0},
        // R7 non-member passes even with links down
        '{1'b1, 2'b00, 1'b1, 3'd3, 48'h1, 48'h0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd3, 1'b0},
        // R7 non-member passes, hash ignored
        '{1'b1, 2'b11, 1'b1, 3'd4, 48'h1, 48'h0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd4, 1'b0},
        // R8 no request; R9 rx 1 learned 0 accepted
        '{1'b1, 2'b11, 1'b0, 3'd3, 48'h1, 48'h0, 1'b1, 3'd1, 3'd0, 1'b0, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        trunk_en;
    logic [1:0]  link_up;
    logic        req_valid;
    logic [2:0]  req_port;
    logic [47:0] sa;
    logic [47:0] da;
    logic        rx_valid;
    logic [2:0]  rx_port;
    logic [2:0]  learned_port;
    logic        sel_valid;
    logic [2:0]  sel_port;
    logic        relearn;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    trunk_selector dut_i (
        .clk          (clk),
        .rst          (rst),
        .trunk_en     (trunk_en),
        .link_up      (link_up),
        .req_valid    (req_valid),
        .req_port     (req_port),
        .sa           (sa),
        .da           (da),
        .rx_valid     (rx_valid),
        .rx_port      (rx_port),
        .learned_port (learned_port),
        .sel_valid    (sel_valid),
        .sel_port     (sel_port),
        .relearn      (relearn)
    );

    task automatic check(string req, logic v, logic [2:0] p, logic r,
                         logic ev, logic [2:0] ep, logic er);
        checks++;
        if (v !== ev || p !== ep || r !== er) begin
            fails++;
            $display("FAIL %s: got valid=%0b port=%0d relearn=%0b, expected valid=%0b port=%0d relearn=%0b",
                     req, v, p, r, ev, ep, er);
        end
    endtask

    task automatic drive(vec_t t);
        @(negedge clk);
        trunk_en     = t.te;
        link_up      = t.lk;
        req_valid    = t.rv;
        req_port     = t.rp;
        sa           = t.sa;
        da           = t.da;
        rx_valid     = t.xv;
        rx_port      = t.xp;
        learned_port = t.lp;
    endtask

    task automatic run(vec_t t, string req);
        drive(t);
        @(posedge clk);
        #1;
        check(req, sel_valid, sel_port, relearn, t.ev, t.ep, t.er);
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        vec_t t;
        rst = 1'b1;
        trunk_en = 1'b1; link_up = 2'b11; req_valid = 1'b1; req_port = 3'd2;
        sa = '0; da = '0; rx_valid = 1'b1; rx_port = 3'd0; learned_port = 3'd4;
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", sel_valid, sel_port, relearn, 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0; req_valid = 1'b0; rx_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after release", sel_valid, sel_port, relearn, 1'b0, 3'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], $sformatf("vector %0d (R3..R11)", i));
        end

        // R2: request applied, outputs unchanged until the edge
        t = VECS[4];
        drive(t);
        #3;
        check("R2 before edge", sel_valid, sel_port, relearn, 1'b0, 3'd0, 1'b0);
        @(posedge clk);
        #1;
        check("R2 after edge", sel_valid, sel_port, relearn, t.ev, t.ep, t.er);

        // R4: same pair repeated keeps the same member
        t = VECS[5];
        run(t, "R4 repeat 1");
        t.rp = 3'd0;
        run(t, "R4 repeat 2");

        // R6 then recovery to R4 once links return
        t = VECS[8];
        run(t, "R6 both down again");
        t.lk = 2'b11; t.ev = 1'b1; t.ep = 3'd1;
        run(t, "R4 after links return");

        // R11: rx idle with mismatching learned port
        t = VECS[0];
        t.xv = 1'b0; t.er = 1'b0;
        run(t, "R11 idle rx");

        // R1: reset mid-run clears outputs
        t = VECS[0];
        drive(t);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", sel_valid, sel_port, relearn, 1'b0, 3'd0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule